// File: doc/BRIEF.md
# Cluster Performance Counter Unit

This block counts activity for a group of cores that share one memory system. It holds a parameter-set number of 32-bit event counters and one 64-bit cycle counter. Each event counter is programmed with an event code. The code either picks one of the per-cycle event pulse lines from the cluster, or it selects the clock itself, or it selects the wrap of the counter just below it so that two counters form one wider count. When any counter wraps, its overflow flag is set. A single level interrupt is raised while an overflow flag is set whose interrupt enable is also set.

Software reaches the unit through a word-addressed register port. The request channel and the response channel each use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Exactly one response follows for every request, on the next cycle. While a response is held back by a low `rsp_ready`, the port refuses new requests, and the response data does not change until it is taken. A write takes effect on the edge where it is accepted. A read returns the state as it was just before that edge.

Top module: `cluster_pmu`

## Requirements
- R1: After reset all counters, both enable masks, the overflow flags, the select index and the global enable are zero, and `irq` is low. The control register (address 0) reads the implementer code in bits 31:24, the identification code in bits 23:16, the number of event counters in bits 15:11, and the global enable in bit 0. All other bits read zero.
- R2: `req_ready` is low whenever a response is pending with `rsp_ready` low. A stalled response keeps `rsp_valid` high and its data unchanged. Every request gets exactly one response, in request order, and a write's response data is zero.
- R3: Event counter n, programmed with code k (k below `NUM_EVT_IN`, other than 0x11 and 0x1E), adds one on each clock edge where `evt_in[k]` is high, but only while control bit 0 and enable bit n are both set. Codes at or above `NUM_EVT_IN` never count.
- R4: The counter-enable mask is written through address 1 (write-one-to-set) and address 2 (write-one-to-clear). The interrupt-enable mask uses address 6 (set) and address 7 (clear). Zero bits leave the mask unchanged. Both addresses of a pair read the current mask. Bit n is event counter n and bit 31 is the cycle counter. Bits that do not stand for an implemented counter always read zero.
- R5: The select register is at address 5 and holds 5 bits. The event-type window (address 10) and the count window (address 11) act on the selected counter. An index that is neither below the counter count nor 31 reads zero in both windows, and writes to it are ignored. At index 31, the type window reads 0x11 and ignores writes, and the count window reaches bits 31:0 of the cycle counter.
- R6: An event counter that increments from 0xFFFFFFFF wraps to zero and sets its overflow bit n.
- R7: Reading address 4 returns the pending overflow bits. Writing a value there clears exactly its one bits. Writing address 3 sets its one bits. A wrap in the same cycle as a clear leaves the bit set.
- R8: `irq` is high exactly when some overflow bit and its interrupt-enable bit are both set. It stays high until that overflow bit or that enable bit is cleared.
- R9: The cycle counter increments on every clock edge where control bit 0 and enable bit 31 are set. Its halves are at address 8 (bits 31:0) and address 9 (bits 63:32). A wrap from all ones sets overflow bit 31.
- R10: Writing control bit 1 zeroes every event counter. Writing control bit 2 zeroes the cycle counter. Both bits read back as zero. Writes to the read-only fields have no effect.
- R11: Code 0x11 makes an event counter count every enabled cycle. Code 0x1E makes counter n count the wraps of counter n-1, in the same cycle as the wrap. Counter 0 with code 0x1E never counts.
- R12: Addresses 12 and 13 are read-only. They return bits 31:0 and 63:32 of the event-availability map, in which bit k set means that common event code k is implemented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken on this edge if valid |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| evt_in | input | NUM_EVT_IN | Per-cycle event pulses, line k = event code k |
| irq | output | 1 | Overflow interrupt, level |

## Verification
Every piece of state in this block is visible at the ports: the masks and flags through their own addresses, and the counters through the select windows. A wrong increment, a missed wrap or a stuck flag therefore shows in the very next read, or, for an overflow that is enabled as an interrupt, on `irq` one cycle after the edge in question. Counts are read only while the global enable is off. The exact length of each enabled window is taken from the bench's own record of which edges accepted requests, so any error of one edge in the enable gating shows up as a count that is off by one. A fault in the response buffer shows as data that changes during a stall, or as a response that is lost or duplicated against the ordered list of expected values.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W  = 32;
  localparam int TYPE_W  = 8;
  localparam int CYC_BIT = 31;
  localparam logic [TYPE_W-1:0] EVT_CYCLES = 8'h11;
  localparam logic [TYPE_W-1:0] EVT_CHAIN  = 8'h1E;

  typedef enum logic [3:0] {
    RA_CTRL    = 4'd0,
    RA_EN_SET  = 4'd1,
    RA_EN_CLR  = 4'd2,
    RA_OVF_SET = 4'd3,
    RA_OVF_CLR = 4'd4,
    RA_SEL     = 4'd5,
    RA_IE_SET  = 4'd6,
    RA_IE_CLR  = 4'd7,
    RA_CYC_LO  = 4'd8,
    RA_CYC_HI  = 4'd9,
    RA_EVTYPE  = 4'd10,
    RA_EVCNT   = 4'd11,
    RA_AVL_LO  = 4'd12,
    RA_AVL_HI  = 4'd13
  } reg_addr_e;
endpackage

// File: rtl/pmu_bus_port.sv
module pmu_bus_port #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          acc,
  output logic          acc_write,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata,
  input  logic [DW-1:0] rd_data
);
  // A new request may enter only when the response slot is free or draining.
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign acc_write = req_write;
  assign acc_addr  = req_addr;
  assign acc_wdata = req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R2: a stalled response stays put
  a_r2_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
endmodule

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter
  import pmu_pkg::*;
#(
  parameter int NUM_EVT_IN = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cnt_en,
  input  logic                  zero,
  input  logic                  wr_type,
  input  logic                  wr_cnt,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [NUM_EVT_IN-1:0] evt_in,
  input  logic                  chain_in,
  output logic [DATA_W-1:0]     count,
  output logic [TYPE_W-1:0]     evtype,
  output logic                  wrap
);
  localparam int IDX_W = (NUM_EVT_IN > 1) ? $clog2(NUM_EVT_IN) : 1;
  localparam logic [TYPE_W:0] CODE_LIM = NUM_EVT_IN[TYPE_W:0];

  logic hit, inc;

  always_comb begin
    case (evtype)
      EVT_CYCLES: hit = 1'b1;
      EVT_CHAIN:  hit = chain_in;
      default:    hit = ({1'b0, evtype} < CODE_LIM) ? evt_in[evtype[IDX_W-1:0]] : 1'b0;
    endcase
  end

  // Software writes and the zeroing strobe win over an increment.
  assign inc  = cnt_en && hit && !zero && !wr_cnt;
  assign wrap = inc && (count == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      evtype <= '0;
    end else begin
      if (wr_type) evtype <= wdata[TYPE_W-1:0];
      if (zero)        count <= '0;
      else if (wr_cnt) count <= wdata;
      else if (inc)    count <= count + 1'b1;
    end
  end

  // R3: a disabled counter with no software access holds its value
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en && !zero && !wr_cnt |=> $stable(count));
  // R6: a wrap leaves the counter at zero
  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> count == '0);
endmodule

// File: rtl/pmu_cyc_counter.sv
module pmu_cyc_counter
  import pmu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_en,
  input  logic                zero,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0] count,
  output logic                wrap
);
  logic inc;
  assign inc  = cnt_en && !zero && !wr_lo && !wr_hi;
  assign wrap = inc && (&count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (zero) begin
      count <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) count[DATA_W-1:0]        <= wdata;
      if (wr_hi) count[2*DATA_W-1:DATA_W] <= wdata;
    end else if (inc) begin
      count <= count + 1'b1;
    end
  end

  // R9: each enabled cycle adds exactly one
  a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/cluster_pmu.sv
module cluster_pmu
  import pmu_pkg::*;
#(
  parameter int          NUM_CNT    = 4,
  parameter int          NUM_EVT_IN = 64,
  parameter logic [7:0]  ID_CODE    = 8'h5A,
  parameter logic [7:0]  IMPL_CODE  = 8'hC3,
  parameter logic [63:0] AVAIL_MAP  = 64'h0000_0123_4002_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [3:0]            req_addr,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [31:0]           rsp_rdata,
  input  logic [NUM_EVT_IN-1:0] evt_in,
  output logic                  irq
);
  localparam logic [DATA_W-1:0] IMPL_MASK =
    32'h8000_0000 | ((32'h1 << NUM_CNT) - 32'h1);
  localparam logic [4:0] N_FIELD = NUM_CNT[4:0];
  localparam logic [5:0] SEL_LIM = NUM_CNT[5:0];
  localparam logic [4:0] CYC_IDX = 5'(CYC_BIT);

  logic              acc, acc_write;
  logic [3:0]        acc_addr;
  logic [DATA_W-1:0] acc_wdata, rd_data;
  reg_addr_e         ra;

  pmu_bus_port #(.AW(4), .DW(DATA_W)) u_port (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_ready, .rsp_rdata,
    .acc, .acc_write, .acc_addr, .acc_wdata, .rd_data
  );

  assign ra = reg_addr_e'(acc_addr);

  logic              glob_en;
  logic [DATA_W-1:0] cnt_en_q, int_en_q, ovf_q, hw_ovf;
  logic [4:0]        sel_q;
  logic              wr, sel_ok, sel_cyc, zero_evt, zero_cyc;

  assign wr       = acc && acc_write;
  assign sel_cyc  = (sel_q == CYC_IDX);
  assign sel_ok   = ({1'b0, sel_q} < SEL_LIM) || sel_cyc;
  assign zero_evt = wr && (ra == RA_CTRL) && acc_wdata[1];
  assign zero_cyc = wr && (ra == RA_CTRL) && acc_wdata[2];

  // ---------------- counters ----------------
  logic [DATA_W-1:0]   cnt_val  [NUM_CNT];
  logic [TYPE_W-1:0]   type_val [NUM_CNT];
  logic                chain_w  [NUM_CNT+1];
  logic [2*DATA_W-1:0] cyc_val;
  logic                cyc_wrap;

  assign chain_w[0] = 1'b0;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic sel_me;
    assign sel_me = (sel_q == 5'(i));
    pmu_evt_counter #(.NUM_EVT_IN(NUM_EVT_IN)) u_cnt (
      .clk, .rst_n,
      .cnt_en   (glob_en && cnt_en_q[i]),
      .zero     (zero_evt),
      .wr_type  (wr && (ra == RA_EVTYPE) && sel_me),
      .wr_cnt   (wr && (ra == RA_EVCNT) && sel_me),
      .wdata    (acc_wdata),
      .evt_in   (evt_in),
      .chain_in (chain_w[i]),
      .count    (cnt_val[i]),
      .evtype   (type_val[i]),
      .wrap     (chain_w[i+1])
    );
  end

  pmu_cyc_counter u_cyc (
    .clk, .rst_n,
    .cnt_en (glob_en && cnt_en_q[CYC_BIT]),
    .zero   (zero_cyc),
    .wr_lo  (wr && ((ra == RA_CYC_LO) || ((ra == RA_EVCNT) && sel_cyc))),
    .wr_hi  (wr && (ra == RA_CYC_HI)),
    .wdata  (acc_wdata),
    .count  (cyc_val),
    .wrap   (cyc_wrap)
  );

  always_comb begin
    hw_ovf = '0;
    hw_ovf[CYC_BIT] = cyc_wrap;
    for (int i = 0; i < NUM_CNT; i++) hw_ovf[i] = chain_w[i+1];
  end

  // ---------------- control state ----------------
  function automatic logic [DATA_W-1:0] w1(input logic hit, input logic [DATA_W-1:0] d);
    return hit ? d : '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en  <= 1'b0;
      cnt_en_q <= '0;
      int_en_q <= '0;
      ovf_q    <= '0;
      sel_q    <= '0;
    end else begin
      if (wr && (ra == RA_CTRL)) glob_en <= acc_wdata[0];
      if (wr && (ra == RA_SEL))  sel_q   <= acc_wdata[4:0];
      cnt_en_q <= (cnt_en_q | w1(wr && ra == RA_EN_SET, acc_wdata))
                  & ~w1(wr && ra == RA_EN_CLR, acc_wdata) & IMPL_MASK;
      int_en_q <= (int_en_q | w1(wr && ra == RA_IE_SET, acc_wdata))
                  & ~w1(wr && ra == RA_IE_CLR, acc_wdata) & IMPL_MASK;
      // A wrap in the same cycle as a clear keeps its flag.
      ovf_q    <= (((ovf_q | w1(wr && ra == RA_OVF_SET, acc_wdata))
                  & ~w1(wr && ra == RA_OVF_CLR, acc_wdata)) | hw_ovf) & IMPL_MASK;
    end
  end

  assign irq = |(ovf_q & int_en_q);

  // ---------------- read mux ----------------
  always_comb begin
    rd_data = '0;
    case (ra)
      RA_CTRL:               rd_data = {IMPL_CODE, ID_CODE, N_FIELD, 10'b0, glob_en};
      RA_EN_SET, RA_EN_CLR:  rd_data = cnt_en_q;
      RA_IE_SET, RA_IE_CLR:  rd_data = int_en_q;
      RA_OVF_SET, RA_OVF_CLR: rd_data = ovf_q;
      RA_SEL:                rd_data = {27'b0, sel_q};
      RA_CYC_LO:             rd_data = cyc_val[DATA_W-1:0];
      RA_CYC_HI:             rd_data = cyc_val[2*DATA_W-1:DATA_W];
      RA_AVL_LO:             rd_data = AVAIL_MAP[31:0];
      RA_AVL_HI:             rd_data = AVAIL_MAP[63:32];
      RA_EVTYPE: begin
        if (sel_cyc) rd_data = {24'b0, EVT_CYCLES};
        for (int i = 0; i < NUM_CNT; i++)
          if (sel_q == 5'(i)) rd_data = {24'b0, type_val[i]};
      end
      RA_EVCNT: begin
        if (sel_cyc) rd_data = cyc_val[DATA_W-1:0];
        for (int i = 0; i < NUM_CNT; i++)
          if (sel_q == 5'(i)) rd_data = cnt_val[i];
      end
      default: rd_data = '0;
    endcase
    if (!sel_ok && (ra == RA_EVTYPE || ra == RA_EVCNT)) rd_data = '0;
  end

  // R9: a cycle-counter wrap raises overflow bit 31
  a_r9_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wrap |=> ovf_q[CYC_BIT]);
  // R8: the interrupt holds until software clears a flag or an enable
  a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(wr && (ra == RA_OVF_CLR || ra == RA_IE_CLR)) |=> irq);
  // R7: a counter wrap always leaves its flag set
  a_r7_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    chain_w[1] |=> ovf_q[0]);
endmodule

// File: tb/tb_cluster_pmu.sv
module tb_cluster_pmu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;
  logic [63:0] evt = '0;

  always #2 clk = ~clk;

  cluster_pmu #(.NUM_CNT(4), .NUM_EVT_IN(64), .ID_CODE(8'h5A), .IMPL_CODE(8'hC3),
                .AVAIL_MAP(64'h0000_0123_4002_0000)) dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_ready, .rsp_rdata, .evt_in(evt), .irq);

  int unsigned n_chk = 0, n_fail = 0, cyc = 0, last_acc = 0;
  bit          done = 0, bp = 0;
  logic [31:0] q_exp[$];
  string       q_tag[$];
  logic [7:0]  lf = 8'hA5;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: issue one request and push the expected response.
  task automatic xfer(bit w, logic [3:0] a, logic [31:0] d, logic [31:0] exp, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    q_exp.push_back(exp); q_tag.push_back(tag);
    forever begin #1; if (req_ready) break; @(negedge clk); end
    @(posedge clk); #1;
    last_acc = cyc;
    req_valid = 1'b0;
  endtask
  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag); xfer(1'b0, a, '0, exp, tag); endtask
  task automatic wr(logic [3:0] a, logic [31:0] d, string tag);   xfer(1'b1, a, d, '0, tag);   endtask

  task automatic pulse(int idx, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); evt[idx] = 1'b1;
      @(negedge clk); evt[idx] = 1'b0;
    end
  endtask

  task automatic drain();
    while (q_exp.size() != 0 || rsp_valid) @(negedge clk);
  endtask

  // Monitor: back-pressure, stall checks and scoreboard compare.
  initial begin
    bit          stalled = 0;
    logic [31:0] held = '0;
    forever begin
      @(negedge clk);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      rsp_ready = bp ? lf[0] : 1'b1;
      #1;
      if (stalled) begin
        check("R2 stalled response held", {31'b0, rsp_valid, rsp_rdata}, {31'b0, 1'b1, held});
      end
      if (rsp_valid && !rsp_ready) begin
        check("R2 no request taken while stalled", {63'b0, req_ready}, 64'd0);
        stalled = 1; held = rsp_rdata;
      end else stalled = 0;
      if (rsp_valid && rsp_ready) begin
        if (q_exp.size() == 0) check("R2 unexpected response", 64'd1, 64'd0);
        else begin
          logic [31:0] e;
          string t;
          e = q_exp.pop_front(); t = q_tag.pop_front();
          check(t, {32'b0, rsp_rdata}, {32'b0, e});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned e1, e2, d;
    logic [63:0] cv;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq low", {63'b0, irq}, 64'd0);
    rd(4'd0,  32'hC35A_2000, "R1 control fields");
    rd(4'd1,  32'h0, "R1 enable mask zero");
    rd(4'd4,  32'h0, "R1 overflow zero");
    rd(4'd5,  32'h0, "R1 select zero");
    rd(4'd8,  32'h0, "R1 cycle low zero");
    // R12 availability map
    rd(4'd12, 32'h4002_0000, "R12 avail low");
    rd(4'd13, 32'h0000_0123, "R12 avail high");
    // R4 set/clear masks
    wr(4'd1, 32'hFFFF_FFFF, "R2 write ack");
    rd(4'd2, 32'h8000_000F, "R4 set all implemented only");
    wr(4'd2, 32'h0000_0005, "R2 write ack");
    rd(4'd1, 32'h8000_000A, "R4 clear leaves others");
    wr(4'd6, 32'h8000_0006, "R2 write ack");
    wr(4'd7, 32'h8000_0004, "R2 write ack");
    rd(4'd6, 32'h0000_0002, "R4 interrupt mask");
    // R5 select windows
    wr(4'd5, 32'd2, "R2 write ack");  wr(4'd10, 32'h03, "R2 write ack");
    rd(4'd10, 32'h03, "R5 type window");
    wr(4'd5, 32'd1, "R2 write ack");  wr(4'd10, 32'h04, "R2 write ack");
    wr(4'd5, 32'd9, "R2 write ack");
    wr(4'd10, 32'h07, "R2 write ack"); wr(4'd11, 32'h5, "R2 write ack");
    rd(4'd10, 32'h0, "R5 unimplemented type reads zero");
    rd(4'd11, 32'h0, "R5 unimplemented count reads zero");
    rd(4'd5,  32'd9, "R5 select readback");
    wr(4'd5, 32'd2, "R2 write ack");
    rd(4'd10, 32'h03, "R5 ignored write left counter 2");
    rd(4'd11, 32'h0,  "R5 ignored write left count 2");
    // R3 gating
    wr(4'd2, 32'hFFFF_FFFF, "R2 write ack"); wr(4'd1, 32'h6, "R2 write ack");
    pulse(3, 3);
    wr(4'd0, 32'h1, "R2 write ack");
    pulse(3, 2); pulse(4, 5); pulse(0, 2);
    wr(4'd0, 32'h0, "R2 write ack");
    rd(4'd11, 32'd2, "R3 counter 2 counts only while enabled");
    wr(4'd5, 32'd1, "R2 write ack");
    rd(4'd11, 32'd5, "R3 counter 1 counts its line");
    wr(4'd5, 32'd0, "R2 write ack");
    rd(4'd11, 32'd0, "R3 counter 0 disabled");
    // R6 R7 R8 overflow and interrupt
    wr(4'd5, 32'd1, "R2 write ack"); wr(4'd11, 32'hFFFF_FFFE, "R2 write ack");
    wr(4'd0, 32'h1, "R2 write ack");
    pulse(4, 2);
    @(negedge clk);
    check("R8 irq on enabled overflow", {63'b0, irq}, 64'd1);
    wr(4'd0, 32'h0, "R2 write ack");
    rd(4'd11, 32'h0, "R6 wrapped to zero");
    rd(4'd4, 32'h2, "R6 overflow bit 1");
    @(negedge clk);
    check("R8 irq held", {63'b0, irq}, 64'd1);
    wr(4'd4, 32'h2, "R2 write ack");
    @(negedge clk);
    check("R8 irq cleared", {63'b0, irq}, 64'd0);
    rd(4'd4, 32'h0, "R7 clear exact bits");
    wr(4'd3, 32'h8000_0001, "R2 write ack");
    wr(4'd3, 32'h0000_0100, "R2 write ack");
    rd(4'd4, 32'h8000_0001, "R7 set bits, unimplemented dropped");
    @(negedge clk);
    check("R8 irq needs interrupt enable", {63'b0, irq}, 64'd0);
    wr(4'd4, 32'h0000_0001, "R2 write ack");
    rd(4'd3, 32'h8000_0000, "R7 clear only written bits");
    wr(4'd4, 32'h8000_0000, "R2 write ack");
    // R11 chain and cycle code
    wr(4'd11, 32'hFFFF_FFFF, "R2 write ack");
    wr(4'd5, 32'd2, "R2 write ack"); wr(4'd11, 32'h0, "R2 write ack");
    wr(4'd10, 32'h1E, "R2 write ack");
    wr(4'd5, 32'd3, "R2 write ack"); wr(4'd10, 32'h11, "R2 write ack");
    wr(4'd1, 32'h8, "R2 write ack");
    wr(4'd0, 32'h1, "R2 write ack"); e1 = last_acc;
    pulse(4, 1);
    wr(4'd0, 32'h0, "R2 write ack"); e2 = last_acc;
    rd(4'd11, e2 - e1, "R11 cycles code counts each enabled edge");
    wr(4'd5, 32'd2, "R2 write ack");
    rd(4'd11, 32'd1, "R11 chained counter took the wrap");
    wr(4'd5, 32'd1, "R2 write ack");
    rd(4'd11, 32'd0, "R11 lower counter wrapped");
    rd(4'd4, 32'h2, "R11 lower overflow flag");
    wr(4'd4, 32'h2, "R2 write ack");
    // R9 cycle counter
    wr(4'd8, 32'hFFFF_FFFF, "R2 write ack"); wr(4'd9, 32'h1, "R2 write ack");
    rd(4'd9, 32'h1, "R9 high half write");
    wr(4'd1, 32'h8000_0000, "R2 write ack");
    wr(4'd0, 32'h1, "R2 write ack"); e1 = last_acc;
    repeat (3) @(negedge clk);
    wr(4'd0, 32'h0, "R2 write ack"); e2 = last_acc;
    cv = 64'h1_FFFF_FFFF + 64'(e2 - e1);
    rd(4'd8, cv[31:0],  "R9 low after carry");
    rd(4'd9, cv[63:32], "R9 high after carry");
    wr(4'd8, 32'hFFFF_FFFF, "R2 write ack"); wr(4'd9, 32'hFFFF_FFFF, "R2 write ack");
    wr(4'd0, 32'h1, "R2 write ack"); e1 = last_acc;
    repeat (2) @(negedge clk);
    wr(4'd0, 32'h0, "R2 write ack"); e2 = last_acc;
    d = e2 - e1;
    rd(4'd8, d - 1, "R9 wrap low");
    rd(4'd9, 32'h0, "R9 wrap high");
    rd(4'd4, 32'h8000_0000, "R9 wrap sets bit 31");
    // R10 zeroing strobes, read-only fields, cycle window
    wr(4'd5, 32'd3, "R2 write ack");
    wr(4'd0, 32'h2, "R2 write ack");
    rd(4'd11, 32'h0, "R10 event counters zeroed");
    rd(4'd8, d - 1, "R10 bit 1 leaves cycle counter");
    wr(4'd0, 32'h4, "R2 write ack");
    rd(4'd8, 32'h0, "R10 cycle counter zeroed");
    wr(4'd5, 32'd31, "R2 write ack");
    wr(4'd11, 32'h1234, "R2 write ack");
    wr(4'd10, 32'h05, "R2 write ack");
    rd(4'd8, 32'h1234, "R5 count window reaches cycle counter");
    rd(4'd10, 32'h11, "R5 index 31 type fixed");
    wr(4'd0, 32'hFFFF_F801, "R2 write ack");
    rd(4'd0, 32'hC35A_2001, "R10 read-only fields kept");
    wr(4'd0, 32'h0, "R2 write ack");
    // R2 back-pressure
    bp = 1;
    for (int k = 0; k < 6; k++) begin
      rd(4'd13, 32'h0000_0123, "R2 read under stall");
      wr(4'd5, 32'(k), "R2 write ack under stall");
      rd(4'd5, 32'(k), "R2 ordered read under stall");
    end
    drain();
    bp = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule